// File: doc/BRIEF.md
# Single-Bit-Step Toggle Counter

This block is a three-bit synchronous counter that visits all eight codes in a fixed order in which neighbouring codes differ in exactly one bit: 0, 4, 5, 7, 6, 2, 3, 1, and then 0 again. It is suited to places where a small state code must never pass through a transient multi-bit change, such as a phase selector or a code that a slower domain samples.

The counter is made of three toggle cells, one per bit. Each cell inverts its stored bit on a rising clock edge when its toggle input is high, and keeps the bit when that input is low. The toggle inputs are combinational functions of the present code. Bit 0 toggles when the code has odd parity. When the parity is even, bit 1 toggles if bit 0 is set, and bit 2 toggles if bit 0 is clear.

A synchronous active-high reset clears the code to 0 and overrides everything else. An active-high count enable freezes the code when it is low.

Top module: `gray_tcount`

## Requirements
- R1: When `rst` is 1 at a rising edge of `clk`, `state` is 0 after that edge, whatever the value of `cnt_en`.
- R2: With `rst` at 0 and `cnt_en` at 1, `state` goes from 0 to 4, 4 to 5, 5 to 7, 7 to 6, 6 to 2, 2 to 3, 3 to 1 and 1 to 0. It moves one place on each rising edge, and this repeats without end, including the wrap from 1 back to 0.
- R3: On every enabled step, the new `state` differs from the previous `state` in exactly one bit.
- R4: With `rst` at 0 and `cnt_en` at 0, `state` keeps its value across a rising edge.
- R5: On an enabled step, bit 0 of `state` inverts exactly when the previous `state` had an odd number of ones.
- R6: A reset applied in the middle of the sequence returns `state` to 0 at the next edge. The first enabled step after that gives 4.
- R7: A reset applied while `cnt_en` is 0 still clears `state` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every cell updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to code 0 |
| cnt_en | input | 1 | Active-high count enable; when low, the code is held |
| state | output | 3 | Present code of the counter |

## Verification
Every result of this block is due exactly one rising edge after the inputs that produce it. This holds for a step, a hold and a reset alike, because each bit passes through a single register. The driver sets `rst` and `cnt_en` on the falling edge and queues the code the table model predicts for the next rising edge. The monitor reads `state` a short time after that rising edge, so each queued item meets the result of the same edge. On enabled steps, the monitor also compares the new code with the code it saw on the edge before, to check the one-bit change and the parity rule.

// File: rtl/gray_tcount.sv
module gray_tcount (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  output logic [2:0] state
);

  logic       par;
  logic [2:0] tgl;

  assign par    = ^state;
  assign tgl[0] = cnt_en & par;
  assign tgl[1] = cnt_en & ~par & state[0];
  assign tgl[2] = cnt_en & ~par & ~state[0];

  for (genvar i = 0; i < 3; i++) begin : g_cell
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)         bit_q <= 1'b0;
      else if (tgl[i]) bit_q <= ~bit_q;
    end
    assign state[i] = bit_q;
  end

  logic seen_rst;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (state == 3'd0));

  p_wrap_zero_to_four_r2: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (cnt_en && state == 3'd0) |=> (state == 3'd4));

  p_one_bit_step_r3: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    cnt_en |=> ($countones(state ^ $past(state)) == 1));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    !cnt_en |=> $stable(state));

  p_lsb_parity_r5: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    cnt_en |=> ((state[0] != $past(state[0])) == (^$past(state))));

endmodule

// File: tb/gray_tcount_tb.sv
module gray_tcount_tb;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic [2:0] state;

  int n_cmp = 0;
  int n_bad = 0;

  logic [2:0] exp_q[$];
  logic       stp_q[$];
  string      req_q[$];

  logic [2:0] order [8] = '{3'd0, 3'd4, 3'd5, 3'd7, 3'd6, 3'd2, 3'd3, 3'd1};
  int idx = 0;
  bit done = 0;

  gray_tcount u_dut (.clk(clk), .rst(rst), .cnt_en(cnt_en), .state(state));

  always #(PERIOD/2) clk = ~clk;

  task automatic drive(input logic r, input logic e, input string req);
    @(negedge clk);
    rst = r;
    cnt_en = e;
    if (r) idx = 0;
    else if (e) idx = (idx + 1) % 8;
    exp_q.push_back(order[idx]);
    stp_q.push_back(!r && e);
    req_q.push_back(req);
  endtask

  initial begin : monitor
    logic [2:0] prev;
    prev = 3'd0;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        logic s;
        string rq;
        e = exp_q.pop_front();
        s = stp_q.pop_front();
        rq = req_q.pop_front();
        n_cmp++;
        if (state !== e) begin
          n_bad++;
          $display("FAIL %s: state=%0d expected=%0d", rq, state, e);
        end
        if (s) begin
          n_cmp++;
          if ($countones(state ^ prev) != 1) begin
            n_bad++;
            $display("FAIL R3: changed bits=%0d expected=1 (prev=%0d now=%0d)",
                     $countones(state ^ prev), prev, state);
          end
          n_cmp++;
          if ((state[0] != prev[0]) != (^prev)) begin
            n_bad++;
            $display("FAIL R5: lsb flip=%0b expected=%0b (prev=%0d)",
                     state[0] != prev[0], ^prev, prev);
          end
        end
        prev = state;
      end
    end
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    drive(1'b1, 1'b0, "R1");
    drive(1'b1, 1'b1, "R1");
    for (int k = 0; k < 24; k++) drive(1'b0, 1'b1, "R2");
    for (int k = 0; k < 3; k++) drive(1'b0, 1'b1, "R2");
    for (int k = 0; k < 4; k++) drive(1'b0, 1'b0, "R4");
    for (int k = 0; k < 2; k++) drive(1'b0, 1'b1, "R2");
    drive(1'b1, 1'b1, "R6");
    drive(1'b0, 1'b1, "R6");
    for (int k = 0; k < 5; k++) drive(1'b0, 1'b1, "R2");
    drive(1'b0, 1'b0, "R4");
    drive(1'b1, 1'b0, "R7");
    drive(1'b0, 1'b0, "R4");
    for (int k = 0; k < 10; k++) drive(1'b0, 1'b1, "R2");
    drive(1'b0, 1'b0, "R4");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule